// File: doc/BRIEF.md
# Parcel-Addressed Instruction Prefetch Cache

This block is the fetch front end of an instruction pipeline whose instructions are one or two 16-bit parcels long, while memory returns 64-bit words. It keeps four whole-line buffers of sixteen words each. Every cycle a valid fetch request carries a parcel address. The block compares that address against the tag of every buffer at once, so any line may sit in any buffer. When the lookup hits, the request is accepted in the same cycle and the parcel is returned one cycle later. A wide request (a 32-bit instruction) also returns the parcel that follows, even when that parcel lies in the next word or the next line.

When a needed line is absent, the block raises a one-cycle fill request with the line address. It then replaces buffers in strict rotation and loads the chosen buffer from a four-beat burst, each beat carrying four words. While the burst runs, the fetch stays stalled. When the burst completes, the lookup is retried. There is no write path into the buffers, so stores to memory never change what the buffers hold.

Top module: `parcel_fetch_cache`

## Requirements
- R1: After reset every buffer is invalid, `rsp_valid` and `req_ready` are low, and the first request of any address raises `mem_req`.
- R2: When `req_valid` is high, no fill is running and every needed line is present, `req_ready` is high in that same cycle. In the next cycle `rsp_valid` is high and `rsp_first` holds the parcel at `req_addr`. Parcel address bits [1:0] pick bits [16p+15:16p] of the word, bits [5:2] pick the word within the line, and the bits above bit 5 form the line tag.
- R3: For a request with `req_wide` high, `rsp_second` holds the parcel at `req_addr`+1, across word and line boundaries. For a narrow request, `rsp_second` is zero.
- R4: A miss raises `mem_req` for exactly one cycle, with `mem_line` equal to the tag of the missing line. `req_ready` stays low from then until the fill completes.
- R5: During a fill, the k-th cycle with `mem_rvalid` high (k = 0..3) supplies words 4k..4k+3 of the line, with word 4k+j in `mem_rdata` bits [64j+63:64j]. After the fourth beat the held request is looked up again.
- R6: Fills replace buffers 0, 1, 2, 3, 0, … in turn. The rotation advances only when a fill starts and never on a hit.
- R7: For a wide request, if the first line is present and the next line is not, the next line is filled. If both are absent, the first line is filled, then the next one, before the request is accepted.
- R8: `mem_rvalid` pulses while no fill is running have no effect on buffer contents, and no new `mem_req` is raised while a fill is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present, held until accepted |
| req_addr | input | PA_W (24) | Parcel address of the first parcel |
| req_wide | input | 1 | Request also needs the following parcel |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response parcels valid |
| rsp_first | output | 16 | Parcel at the accepted address |
| rsp_second | output | 16 | Following parcel for wide requests, else zero |
| mem_req | output | 1 | One-cycle line fill request |
| mem_line | output | PA_W-6 (18) | Line address of the fill |
| mem_rvalid | input | 1 | Fill beat present |
| mem_rdata | input | 256 | Four words of one fill beat |

## Verification
`req_ready` and `mem_req` are combinational on the request, so they are due in the cycle the request is driven. `rsp_valid` and the response parcels are registered and are due one cycle after acceptance. A fill stalls the request until the cycle after the fourth beat, and a hit can appear no earlier than that. The bench drives inputs just after the falling edge and compares all outputs against a behavioural model one time unit later. It then advances the model as the next rising edge would, so every comparison lands in the cycle the result is due. Scenario-level checks also count the fills each fetch costs, and that count shows the replacement order and the handling of wide requests that cross a line.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned PARCEL_W = 16;
  typedef enum logic [0:0] {FILL_IDLE, FILL_BUSY} fill_state_e;
endpackage

// File: rtl/pfc_tag_match.sv
module pfc_tag_match #(
  parameter int unsigned NBUF  = 4,
  parameter int unsigned TAG_W = 18,
  parameter int unsigned IDX_W = 2
) (
  input  logic [NBUF-1:0][TAG_W-1:0] tags,
  input  logic [NBUF-1:0]            valid,
  input  logic [TAG_W-1:0]           probe,
  output logic                       hit,
  output logic [IDX_W-1:0]           idx
);
  logic [NBUF-1:0] match;

  // one comparator per buffer
  for (genvar b = 0; b < NBUF; b++) begin : g_cmp
    assign match[b] = valid[b] && (tags[b] == probe);
  end

  assign hit = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pfc_fill_seq.sv
module pfc_fill_seq
  import pfc_pkg::*;
#(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned TAG_W  = 18,
  parameter int unsigned BUF_W  = 2,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned BEAT_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [TAG_W-1:0]           start_tag,
  input  logic                       beat_in,
  output logic                       busy,
  output logic                       beat_we,
  output logic [BEAT_W-1:0]          beat_idx,
  output logic [BUF_W-1:0]           fill_buf,
  output logic [NBUF-1:0][TAG_W-1:0] tags,
  output logic [NBUF-1:0]            valid
);
  fill_state_e               state_q, state_d;
  logic [BEAT_W-1:0]         beat_q, beat_d;
  logic [BUF_W-1:0]          ptr_q, ptr_d;
  logic [BUF_W-1:0]          victim_q, victim_d;
  logic [NBUF-1:0][TAG_W-1:0] tags_q, tags_d;
  logic [NBUF-1:0]           valid_q, valid_d;

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    ptr_d    = ptr_q;
    victim_d = victim_q;
    tags_d   = tags_q;
    valid_d  = valid_q;
    case (state_q)
      FILL_IDLE: begin
        if (start) begin
          state_d         = FILL_BUSY;
          beat_d          = '0;
          victim_d        = ptr_q;
          ptr_d           = (ptr_q == BUF_W'(NBUF - 1)) ? '0 : ptr_q + 1'b1;
          tags_d[ptr_q]   = start_tag;
          valid_d[ptr_q]  = 1'b0;
        end
      end
      FILL_BUSY: begin
        if (beat_in) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == BEAT_W'(BEATS - 1)) begin
            state_d           = FILL_IDLE;
            valid_d[victim_q] = 1'b1;
          end
        end
      end
      default: state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FILL_IDLE;
      beat_q   <= '0;
      ptr_q    <= '0;
      victim_q <= '0;
      tags_q   <= '0;
      valid_q  <= '0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      ptr_q    <= ptr_d;
      victim_q <= victim_d;
      tags_q   <= tags_d;
      valid_q  <= valid_d;
    end
  end

  assign busy     = (state_q == FILL_BUSY);
  assign beat_we  = busy && beat_in;
  assign beat_idx = beat_q;
  assign fill_buf = victim_q;
  assign tags     = tags_q;
  assign valid    = valid_q;
endmodule

// File: rtl/pfc_line_store.sv
module pfc_line_store
  import pfc_pkg::*;
#(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned WORDS  = 16,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned BUF_W  = 2,
  parameter int unsigned BEAT_W = 2,
  parameter int unsigned OFF_W  = 6,
  localparam int unsigned WPB    = WORDS / BEATS,
  localparam int unsigned WPB_W  = $clog2(WPB),
  localparam int unsigned WSEL_W = $clog2(WORDS),
  localparam int unsigned PSEL_W = OFF_W - WSEL_W
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [BUF_W-1:0]        wbuf,
  input  logic [BEAT_W-1:0]       wbeat,
  input  logic [WPB*WORD_W-1:0]   wdata,
  input  logic [BUF_W-1:0]        rbuf0,
  input  logic [OFF_W-1:0]        roff0,
  input  logic [BUF_W-1:0]        rbuf1,
  input  logic [OFF_W-1:0]        roff1,
  output logic [PARCEL_W-1:0]     parcel0,
  output logic [PARCEL_W-1:0]     parcel1
);
  logic [WORD_W-1:0] store_q [NBUF][WORDS];
  logic [WORD_W-1:0] word0, word1;

  // line storage is not reset; valid bits in the sequencer guard it
  always_ff @(posedge clk) begin
    if (we) begin
      for (int j = 0; j < WPB; j++) begin
        store_q[wbuf][{wbeat, WPB_W'(j)}] <= wdata[j*WORD_W +: WORD_W];
      end
    end
  end

  assign word0   = store_q[rbuf0][roff0[OFF_W-1:PSEL_W]];
  assign word1   = store_q[rbuf1][roff1[OFF_W-1:PSEL_W]];
  assign parcel0 = word0[roff0[PSEL_W-1:0]*PARCEL_W +: PARCEL_W];
  assign parcel1 = word1[roff1[PSEL_W-1:0]*PARCEL_W +: PARCEL_W];
endmodule

// File: rtl/parcel_fetch_cache.sv
module parcel_fetch_cache
  import pfc_pkg::*;
#(
  parameter int unsigned PA_W   = 24,
  parameter int unsigned NBUF   = 4,
  parameter int unsigned WORDS  = 16,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned BEATS  = 4,
  localparam int unsigned OFF_W  = $clog2(WORDS * WORD_W / PARCEL_W),
  localparam int unsigned TAG_W  = PA_W - OFF_W,
  localparam int unsigned BUF_W  = $clog2(NBUF),
  localparam int unsigned BEAT_W = $clog2(BEATS),
  localparam int unsigned BDAT_W = (WORDS / BEATS) * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [PA_W-1:0]     req_addr,
  input  logic                req_wide,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [PARCEL_W-1:0] rsp_first,
  output logic [PARCEL_W-1:0] rsp_second,
  output logic                mem_req,
  output logic [TAG_W-1:0]    mem_line,
  input  logic                mem_rvalid,
  input  logic [BDAT_W-1:0]   mem_rdata
);
  logic [PA_W-1:0]            next_addr;
  logic [TAG_W-1:0]           tag0, tag1;
  logic                       hit0, hit1, all_hit;
  logic [BUF_W-1:0]           idx0, idx1;
  logic                       busy, beat_we, start;
  logic [BEAT_W-1:0]          beat_idx;
  logic [BUF_W-1:0]           fill_buf;
  logic [NBUF-1:0][TAG_W-1:0] tags;
  logic [NBUF-1:0]            valid;
  logic [PARCEL_W-1:0]        parcel0, parcel1;
  logic                       rsp_valid_q, rsp_valid_d;
  logic [PARCEL_W-1:0]        first_q, first_d, second_q, second_d;

  assign next_addr = req_addr + 1'b1;
  assign tag0      = req_addr[PA_W-1:OFF_W];
  assign tag1      = next_addr[PA_W-1:OFF_W];

  pfc_tag_match #(.NBUF(NBUF), .TAG_W(TAG_W), .IDX_W(BUF_W)) u_match0 (
    .tags(tags), .valid(valid), .probe(tag0), .hit(hit0), .idx(idx0)
  );

  pfc_tag_match #(.NBUF(NBUF), .TAG_W(TAG_W), .IDX_W(BUF_W)) u_match1 (
    .tags(tags), .valid(valid), .probe(tag1), .hit(hit1), .idx(idx1)
  );

  assign all_hit   = hit0 && (!req_wide || hit1);
  assign req_ready = req_valid && !busy && all_hit;
  assign start     = req_valid && !busy && !all_hit;
  assign mem_req   = start;
  // the first line is filled first; the following line only once the first is present
  assign mem_line  = hit0 ? tag1 : tag0;

  pfc_fill_seq #(
    .NBUF(NBUF), .TAG_W(TAG_W), .BUF_W(BUF_W), .BEATS(BEATS), .BEAT_W(BEAT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_tag(mem_line),
    .beat_in(mem_rvalid), .busy(busy), .beat_we(beat_we), .beat_idx(beat_idx),
    .fill_buf(fill_buf), .tags(tags), .valid(valid)
  );

  pfc_line_store #(
    .NBUF(NBUF), .WORDS(WORDS), .WORD_W(WORD_W), .BEATS(BEATS),
    .BUF_W(BUF_W), .BEAT_W(BEAT_W), .OFF_W(OFF_W)
  ) u_store (
    .clk(clk), .we(beat_we), .wbuf(fill_buf), .wbeat(beat_idx), .wdata(mem_rdata),
    .rbuf0(idx0), .roff0(req_addr[OFF_W-1:0]),
    .rbuf1(idx1), .roff1(next_addr[OFF_W-1:0]),
    .parcel0(parcel0), .parcel1(parcel1)
  );

  always_comb begin
    rsp_valid_d = req_ready;
    first_d     = first_q;
    second_d    = second_q;
    if (req_ready) begin
      first_d  = parcel0;
      second_d = req_wide ? parcel1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      first_q     <= '0;
      second_q    <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      first_q     <= first_d;
      second_q    <= second_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_first  = first_q;
  assign rsp_second = second_q;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int unsigned BUF_W = 2,
  parameter int unsigned BEATS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_req,
  input logic             mem_rvalid,
  input logic [BUF_W-1:0] rr_ptr
);
  logic        fill_on;
  int unsigned beats_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_on    <= 1'b0;
      beats_seen <= 0;
    end else if (mem_req) begin
      fill_on    <= 1'b1;
      beats_seen <= 0;
    end else if (fill_on && mem_rvalid) begin
      if (beats_seen == BEATS - 1) fill_on <= 1'b0;
      beats_seen <= beats_seen + 1;
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r4_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_on |-> !req_ready);
  a_r8_no_req_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_on |-> !mem_req);
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  a_r2_no_rsp_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  a_r6_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (rr_ptr == BUF_W'($past(rr_ptr) + 1'b1)));
  a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |=> $stable(rr_ptr));
endmodule

bind parcel_fetch_cache pfc_checker #(.BUF_W(BUF_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .rr_ptr(u_seq.ptr_q)
);

// File: tb/parcel_fetch_cache_test.sv
module parcel_fetch_cache_test;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [23:0]  req_addr;
  logic         req_wide;
  logic         req_ready;
  logic         rsp_valid;
  logic [15:0]  rsp_first;
  logic [15:0]  rsp_second;
  logic         mem_req;
  logic [17:0]  mem_line;
  logic         mem_rvalid;
  logic [255:0] mem_rdata;

  parcel_fetch_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wide(req_wide), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_first(rsp_first), .rsp_second(rsp_second), .mem_req(mem_req),
    .mem_line(mem_line), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural model state
  int m_tag [4];
  bit m_val [4];
  int m_ptr, m_victim, m_beats;
  bit m_busy;
  bit e_rv;
  int e_first, e_second;
  int mcnt, mline;
  bit saw_req;

  function automatic int pf(int a);
    int unsigned x;
    x = (a & 32'hFFFFFF) * 32'd40503;
    return int'((x ^ (x >> 16) ^ (a >> 3)) & 32'hFFFF);
  endfunction

  function automatic bit mhit(int t);
    for (int i = 0; i < 4; i++) if (m_val[i] && m_tag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit v, input int addr, input bit wide, input bit stray);
    int t0, t1, a1, eline;
    bit h0, h1, all, erdy, ereq;
    @(negedge clk);
    if (mcnt >= 1 && mcnt <= 4) begin
      int bi;
      bi = 4 - mcnt;
      mem_rvalid = 1'b1;
      for (int j = 0; j < 4; j++)
        for (int p = 0; p < 4; p++)
          mem_rdata[64*j + 16*p +: 16] = 16'(pf(mline*64 + (bi*4 + j)*4 + p));
    end else if (stray) begin
      mem_rvalid = 1'b1;
      mem_rdata  = '1;
    end else begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
    end
    req_valid = v;
    req_addr  = 24'(addr);
    req_wide  = wide;
    #1;
    t0 = (addr & 32'hFFFFFF) >> 6;
    a1 = (addr + 1) & 32'hFFFFFF;
    t1 = a1 >> 6;
    h0 = mhit(t0);
    h1 = mhit(t1);
    all   = h0 && (!wide || h1);
    erdy  = v && !m_busy && all;
    ereq  = v && !m_busy && !all;
    eline = h0 ? t1 : t0;
    chk(req_ready == erdy, m_busy ? "R4" : "R2", "req_ready", req_ready, erdy);
    chk(mem_req == ereq, m_busy ? "R8" : "R4", "mem_req", mem_req, ereq);
    if (ereq) chk(mem_line == 18'(eline), wide && h0 ? "R7" : "R4", "mem_line", mem_line, eline);
    chk(rsp_valid == e_rv, "R2", "rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin
      chk(rsp_first == 16'(e_first), "R5", "rsp_first", rsp_first, e_first);
      chk(rsp_second == 16'(e_second), "R3", "rsp_second", rsp_second, e_second);
    end
    // advance model to the next rising edge
    e_rv = erdy;
    if (erdy) begin
      e_first  = pf(addr);
      e_second = wide ? pf(a1) : 0;
    end
    if (m_busy && mem_rvalid) begin
      m_beats++;
      if (m_beats == 4) begin
        m_val[m_victim] = 1'b1;
        m_busy = 1'b0;
      end
    end
    if (mcnt > 0) mcnt--;
    if (ereq) begin
      saw_req = 1'b1;
      m_val[m_ptr] = 1'b0;
      m_tag[m_ptr] = eline;
      m_victim = m_ptr;
      m_ptr = (m_ptr + 1) % 4;
      m_busy = 1'b1;
      m_beats = 0;
      mcnt = 6;
      mline = eline;
    end
  endtask

  task automatic fetch(input int addr, input bit wide, input int exp_fills, input string req);
    int fills, n;
    bit done;
    fills = 0;
    n = 0;
    done = 1'b0;
    while (!done && n < 60) begin
      saw_req = 1'b0;
      done = !m_busy && mhit((addr & 32'hFFFFFF) >> 6) &&
             (!wide || mhit(((addr + 1) & 32'hFFFFFF) >> 6));
      step(1'b1, addr, wide, 1'b0);
      if (saw_req) fills++;
      n++;
    end
    chk(done, req, "fetch accepted", done, 1);
    chk(fills == exp_fills, req, "fills taken", fills, exp_fills);
    step(1'b0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_wide = 1'b0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 4; i++) begin m_tag[i] = 0; m_val[i] = 1'b0; end
    m_ptr = 0; m_victim = 0; m_beats = 0; m_busy = 1'b0;
    e_rv = 1'b0; e_first = 0; e_second = 0; mcnt = 0; mline = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b0, "R1", "req_ready after reset", req_ready, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

    fetch(32'h045, 1'b0, 1, "R1");         // cold miss, line 1 -> buffer 0
    fetch(32'h041, 1'b1, 0, "R3");         // wide within a word
    fetch(32'h043, 1'b1, 0, "R3");         // wide across a word
    fetch(32'h07C, 1'b0, 0, "R5");         // last word of line
    fetch(32'h07F, 1'b1, 1, "R7");         // next line missing -> buffer 1
    fetch(32'h07F, 1'b1, 0, "R3");         // across line, both present
    // stray beats while idle
    step(1'b0, 0, 1'b0, 1'b1);
    step(1'b0, 0, 1'b0, 1'b1);
    fetch(32'h080, 1'b0, 0, "R8");
    fetch(32'h05A, 1'b1, 0, "R8");
    // rotation
    fetch(32'h0C7, 1'b0, 1, "R6");         // line 3 -> buffer 2
    fetch(32'h100, 1'b0, 1, "R6");         // line 4 -> buffer 3
    fetch(32'h07E, 1'b1, 0, "R6");         // hits do not move the rotation
    fetch(32'h14D, 1'b0, 1, "R6");         // line 5 evicts line 1
    fetch(32'h0A2, 1'b0, 0, "R6");         // line 2 still held
    fetch(32'h040, 1'b0, 1, "R6");         // line 1 returns, evicts line 2
    fetch(32'h0B3, 1'b1, 1, "R6");         // line 2 gone
    // both lines of a wide request absent
    fetch(32'h2BF, 1'b1, 2, "R7");
    // back-to-back hits over every parcel position
    for (int k = 0; k < 8; k++) fetch(32'h2B8 + k, k[0], 0, "R2");
    for (int k = 0; k < 4; k++) fetch(32'h2C0 + 5*k, 1'b1, 0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule